// File: doc/BRIEF.md
# NAND Bad-Block Check and Mark Engine

This block decides whether a NAND erase block is bad, and retires a block by marking it bad. It does no serial signalling itself. It breaks each request into primitive flash operations and hands them one at a time to a shared serial flash engine through a command port. Each command gets exactly one response back.

A **check** loads a page into the device cache and reads one byte: the first spare byte, just past the 2048-byte data area. If that byte is anything but 0xFF, the block is bad. When the requested page is the first page of its block and its marker reads 0xFF, the check is repeated on the next page. The block is good only if both markers read 0xFF.

A **mark** erases the block that holds the page, then programs the byte 0xF0 into that page's marker position. If the erase fails, the mark stops at once. The result of either request is a one-cycle done pulse carrying a bad flag and a fault flag. A transport error or a failed status is reported as a fault, never as a bad block.

Top module: `nbb_engine`

## Requirements
- R1: `req_ready` is high exactly while no request is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `busy` is high from the cycle after acceptance up to and including the `done` cycle.
- R2: A command is transferred on an edge where `cmd_valid` and `cmd_ready` are both high. While `cmd_valid` is high and `cmd_ready` is low, `cmd_op`, `cmd_page`, `cmd_col` and `cmd_wdata` stay stable. At most one command is outstanding, and the next command is raised only after the response (`rsp_valid`) to the previous one.
- R3: A check issues page-read (op 0) for the page, then cache-read (op 1) at column 2048. The block is reported bad (`res_bad`=1) when the returned `rsp_data` is not 0xFF.
- R4: The second-page check applies only when the first marker reads 0xFF and the page is block-aligned, meaning its low log2(PAGES_PER_BLK) bits are zero. In that case the check repeats on page+1 and the result is good only if both markers are 0xFF. An unaligned page is judged on its own marker alone.
- R5: A response with `rsp_err`=1 during a check ends the request with `res_fault`=1 and `res_bad`=0, and no further command is issued.
- R6: A mark issues write-enable (op 2), then erase (op 3) with the requested page. The erase fails if `rsp_err`=1 or if bits [3:2] of the erase response status byte are non-zero. On a failed erase the request ends with `res_fault`=1 and issues no program command.
- R7: After a good erase, a mark issues:
  - write-enable (op 2);
  - program-load (op 4) at column 2048 with data 0xF0;
  - program-execute (op 5) for the same page.

  Non-zero status bits [3:2] or `rsp_err` on program-execute give `res_fault`=1.
- R8: `done` is a single-cycle pulse. `res_bad` and `res_fault` are valid with it and hold until the next request is accepted. A mark always reports `res_bad`=0.
- R9: After reset, `busy`, `done`, `cmd_valid`, `res_bad` and `res_fault` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_mark | input | 1 | 1 = mark the block bad, 0 = check it |
| req_page | input | PAGE_AW | Page address of the request |
| busy | output | 1 | Request in progress |
| cmd_valid | output | 1 | Command to the flash engine is valid |
| cmd_ready | input | 1 | Flash engine accepts the command |
| cmd_op | output | 3 | Operation code (0 page-read, 1 cache-read, 2 write-enable, 3 erase, 4 program-load, 5 program-execute) |
| cmd_page | output | PAGE_AW | Page address for the command |
| cmd_col | output | COL_W | Cache column for cache-read and program-load, else 0 |
| cmd_wdata | output | 8 | Byte for program-load, else 0 |
| rsp_valid | input | 1 | Response to the outstanding command |
| rsp_data | input | 8 | Byte read, or status byte for erase and program-execute |
| rsp_err | input | 1 | Transport error, timeout or uncorrectable ECC |
| done | output | 1 | One-cycle completion pulse |
| res_bad | output | 1 | Block found bad (check only) |
| res_fault | output | 1 | Request ended on an error |

## Verification
The bench sweeps every page of a small configuration. It uses a flash model whose marker pattern puts non-0xFF bytes on both first and second pages of blocks.

Several failure modes are targeted by this sweep:
- A design that skipped the second page would pass blocks with a bad second-page marker.
- A design that always read two pages would issue extra commands on unaligned pages.
- A design that read the wrong column would see the model's filler byte.

Marks go to every block, some of which fail erase or program in the model. A design that ignored erase status would program a failed block. A design that swallowed the program status would report success.

Marks also land on third and fourth pages. A design that programmed the block's first page instead would turn later checks bad. Randomised `cmd_ready` stalls expose command fields that move under back-pressure. Injected transport errors expose a design that reports them as bad blocks.

// File: rtl/nbb_pkg.sv
package nbb_pkg;

  typedef enum logic [2:0] {
    OP_PAGE_READ = 3'd0,
    OP_CACHE_RD  = 3'd1,
    OP_WREN      = 3'd2,
    OP_ERASE     = 3'd3,
    OP_PROG_LOAD = 3'd4,
    OP_PROG_EXEC = 3'd5
  } nbb_op_e;

  typedef enum logic [2:0] {
    STEP_LOAD,
    STEP_PEEK,
    STEP_WE_ERASE,
    STEP_ERASE,
    STEP_WE_PROG,
    STEP_PLOAD,
    STEP_PEXEC
  } nbb_step_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ISSUE,
    PH_WAIT,
    PH_FIN
  } nbb_phase_e;

  typedef struct packed {
    logic      finish;
    logic      bad;
    logic      fault;
    logic      advance;
    nbb_step_e next;
  } nbb_verdict_t;

endpackage

// File: rtl/nbb_pager.sv
module nbb_pager #(
  parameter int PAGE_AW       = 24,
  parameter int PAGES_PER_BLK = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [PAGE_AW-1:0] load_page,
  input  logic               advance,
  output logic [PAGE_AW-1:0] page,
  output logic               aligned,
  output logic               on_second
);
  localparam int BLK_SH = $clog2(PAGES_PER_BLK);

  logic [PAGE_AW-1:0] page_q;
  logic               second_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q   <= '0;
      second_q <= 1'b0;
    end else if (load) begin
      page_q   <= load_page;
      second_q <= 1'b0;
    end else if (advance) begin
      page_q   <= page_q + 1'b1;
      second_q <= 1'b1;
    end
  end

  generate
    if (BLK_SH > 0) begin : g_align
      assign aligned = (page_q[BLK_SH-1:0] == '0);
    end else begin : g_noalign
      assign aligned = 1'b1;
    end
  endgenerate

  assign page      = page_q;
  assign on_second = second_q;

  assert_page_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!load) && (page_q != $past(page_q)) |-> page_q == $past(page_q) + 1'b1);

endmodule

// File: rtl/nbb_judge.sv
module nbb_judge
  import nbb_pkg::*;
#(
  parameter logic [7:0] MARK_GOOD = 8'hFF,
  parameter int         FAIL_LSB  = 2,
  parameter int         FAIL_MSB  = 3
) (
  input  nbb_step_e    step,
  input  logic [7:0]   rsp_data,
  input  logic         rsp_err,
  input  logic         aligned,
  input  logic         on_second,
  output nbb_verdict_t verdict
);
  logic status_fail;
  assign status_fail = (rsp_data[FAIL_MSB:FAIL_LSB] != '0);

  always_comb begin
    verdict = '{finish: 1'b0, bad: 1'b0, fault: 1'b0, advance: 1'b0, next: step};
    if (rsp_err) begin
      verdict.finish = 1'b1;
      verdict.fault  = 1'b1;
    end else begin
      unique case (step)
        STEP_LOAD:     verdict.next = STEP_PEEK;
        STEP_PEEK: begin
          if (rsp_data != MARK_GOOD) begin
            verdict.finish = 1'b1;
            verdict.bad    = 1'b1;
          end else if (aligned && !on_second) begin
            verdict.advance = 1'b1;
            verdict.next    = STEP_LOAD;
          end else begin
            verdict.finish = 1'b1;
          end
        end
        STEP_WE_ERASE: verdict.next = STEP_ERASE;
        STEP_ERASE: begin
          if (status_fail) begin
            verdict.finish = 1'b1;
            verdict.fault  = 1'b1;
          end else begin
            verdict.next = STEP_WE_PROG;
          end
        end
        STEP_WE_PROG:  verdict.next = STEP_PLOAD;
        STEP_PLOAD:    verdict.next = STEP_PEXEC;
        STEP_PEXEC: begin
          verdict.finish = 1'b1;
          verdict.fault  = status_fail;
        end
        default: begin
          verdict.finish = 1'b1;
          verdict.fault  = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/nbb_seq.sv
module nbb_seq
  import nbb_pkg::*;
#(
  parameter int         COL_W    = 12,
  parameter int         MARK_COL = 2048,
  parameter logic [7:0] MARK_BAD = 8'hF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_mark,
  output logic             req_ready,
  output logic             busy,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [2:0]       cmd_op,
  output logic [COL_W-1:0] cmd_col,
  output logic [7:0]       cmd_wdata,
  input  logic             rsp_valid,
  input  nbb_verdict_t     verdict,
  output nbb_step_e        step,
  output logic             pg_load,
  output logic             pg_advance,
  output logic             done,
  output logic             res_bad,
  output logic             res_fault
);
  nbb_phase_e phase_q;
  nbb_step_e  step_q;
  logic       bad_q, fault_q;
  nbb_op_e    op;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      step_q  <= STEP_LOAD;
      bad_q   <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (req_valid) begin
          phase_q <= PH_ISSUE;
          step_q  <= req_mark ? STEP_WE_ERASE : STEP_LOAD;
          bad_q   <= 1'b0;
          fault_q <= 1'b0;
        end
        PH_ISSUE: if (cmd_ready) phase_q <= PH_WAIT;
        PH_WAIT: if (rsp_valid) begin
          if (verdict.finish) begin
            phase_q <= PH_FIN;
            bad_q   <= verdict.bad;
            fault_q <= verdict.fault;
          end else begin
            phase_q <= PH_ISSUE;
            step_q  <= verdict.next;
          end
        end
        PH_FIN:  phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (step_q)
      STEP_LOAD:     op = OP_PAGE_READ;
      STEP_PEEK:     op = OP_CACHE_RD;
      STEP_ERASE:    op = OP_ERASE;
      STEP_PLOAD:    op = OP_PROG_LOAD;
      STEP_PEXEC:    op = OP_PROG_EXEC;
      default:       op = OP_WREN;
    endcase
  end

  assign req_ready  = (phase_q == PH_IDLE);
  assign busy       = (phase_q != PH_IDLE);
  assign cmd_valid  = (phase_q == PH_ISSUE);
  assign cmd_op     = op;
  assign cmd_col    = (op == OP_CACHE_RD || op == OP_PROG_LOAD) ? COL_W'(MARK_COL) : '0;
  assign cmd_wdata  = (op == OP_PROG_LOAD) ? MARK_BAD : 8'h00;
  assign step       = step_q;
  assign pg_load    = (phase_q == PH_IDLE) && req_valid;
  assign pg_advance = (phase_q == PH_WAIT) && rsp_valid && !verdict.finish && verdict.advance;
  assign done       = (phase_q == PH_FIN);
  assign res_bad    = bad_q;
  assign res_fault  = fault_q;

  assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_col) && $stable(cmd_wdata));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  assert_no_cmd_after_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_valid && busy);

  assert_bad_not_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(res_bad && res_fault));

endmodule

// File: rtl/nbb_engine.sv
module nbb_engine
  import nbb_pkg::*;
#(
  parameter int PAGE_AW       = 24,
  parameter int PAGES_PER_BLK = 64,
  parameter int PAGE_BYTES    = 2048,
  localparam int COL_W        = $clog2(PAGE_BYTES) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_mark,
  input  logic [PAGE_AW-1:0] req_page,
  output logic               busy,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [2:0]         cmd_op,
  output logic [PAGE_AW-1:0] cmd_page,
  output logic [COL_W-1:0]   cmd_col,
  output logic [7:0]         cmd_wdata,
  input  logic               rsp_valid,
  input  logic [7:0]         rsp_data,
  input  logic               rsp_err,
  output logic               done,
  output logic               res_bad,
  output logic               res_fault
);
  localparam logic [7:0] MARK_GOOD = 8'hFF;
  localparam logic [7:0] MARK_BAD  = 8'hF0;

  nbb_step_e    step;
  nbb_verdict_t verdict;
  logic         pg_load, pg_advance, aligned, on_second;

  nbb_pager #(.PAGE_AW(PAGE_AW), .PAGES_PER_BLK(PAGES_PER_BLK)) u_pager (
    .clk(clk), .rst_n(rst_n), .load(pg_load), .load_page(req_page),
    .advance(pg_advance), .page(cmd_page), .aligned(aligned), .on_second(on_second)
  );

  nbb_judge #(.MARK_GOOD(MARK_GOOD), .FAIL_LSB(2), .FAIL_MSB(3)) u_judge (
    .step(step), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .aligned(aligned), .on_second(on_second), .verdict(verdict)
  );

  nbb_seq #(.COL_W(COL_W), .MARK_COL(PAGE_BYTES), .MARK_BAD(MARK_BAD)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mark(req_mark),
    .req_ready(req_ready), .busy(busy), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_col(cmd_col), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
    .verdict(verdict), .step(step), .pg_load(pg_load), .pg_advance(pg_advance),
    .done(done), .res_bad(res_bad), .res_fault(res_fault)
  );

  assert_page_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> $stable(cmd_page));

  assert_peek_column_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 3'd1 |-> cmd_col == COL_W'(PAGE_BYTES));

  assert_load_marker_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 3'd4 |-> cmd_col == COL_W'(PAGE_BYTES) && cmd_wdata == MARK_BAD);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cmd_valid && !done);

endmodule

// File: tb/tb_nbb_engine.sv
module tb_nbb_engine;
  localparam int CLK_PERIOD = 10;
  localparam int PAW   = 8;
  localparam int PPB   = 4;
  localparam int PB    = 2048;
  localparam int CW    = 12;
  localparam int NPAGE = 256;
  localparam int NBLK  = NPAGE / PPB;

  logic clk = 1'b0, rst_n;
  logic req_valid, req_ready, req_mark, busy;
  logic [PAW-1:0] req_page, cmd_page;
  logic cmd_valid, cmd_ready;
  logic [2:0] cmd_op;
  logic [CW-1:0] cmd_col;
  logic [7:0] cmd_wdata, rsp_data;
  logic rsp_valid, rsp_err, done, res_bad, res_fault;
  logic inj_err;

  int nchk = 0, nfail = 0, cyc = 0;

  nbb_engine #(.PAGE_AW(PAW), .PAGES_PER_BLK(PPB), .PAGE_BYTES(PB)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mark(req_mark), .req_page(req_page), .busy(busy), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_page(cmd_page), .cmd_col(cmd_col),
    .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .done(done), .res_bad(res_bad), .res_fault(res_fault)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pat(input int p);
    if (p % 7 == 3) return 8'h3C;
    if (p % 13 == 5) return 8'hFE;
    return 8'hFF;
  endfunction
  function automatic bit efail(input int b); return (b % 5) == 3; endfunction
  function automatic bit pfail(input int b); return (b % 5) == 1; endfunction

  // flash model on the command port
  logic [7:0] mem [NPAGE];
  logic [7:0] cache, pend;
  logic wel, outst, hold_prev;
  logic [15:0] lfsr;
  logic [1:0] pend_cnt;
  logic [2:0] h_op; logic [PAW-1:0] h_page; logic [CW-1:0] h_col; logic [7:0] h_wd;
  int op_total, proto_fail;

  always @(posedge clk) begin
    int pf;
    pf = 0;
    if (!rst_n) begin
      for (int i = 0; i < NPAGE; i++) mem[i] <= pat(i);
      lfsr <= 16'hACE1; cmd_ready <= 1'b0; rsp_valid <= 1'b0; rsp_data <= 8'h00;
      rsp_err <= 1'b0; pend_cnt <= '0; wel <= 1'b0; outst <= 1'b0; hold_prev <= 1'b0;
      op_total <= 0; proto_fail <= 0; cache <= 8'h00; pend <= 8'hFF;
    end else begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cmd_ready <= lfsr[0] | lfsr[3];
      rsp_valid <= 1'b0;
      if (hold_prev && (!cmd_valid || cmd_op != h_op || cmd_page != h_page ||
                        cmd_col != h_col || cmd_wdata != h_wd)) pf++;
      hold_prev <= cmd_valid && !cmd_ready;
      h_op <= cmd_op; h_page <= cmd_page; h_col <= cmd_col; h_wd <= cmd_wdata;
      if (pend_cnt != 0) begin
        pend_cnt <= pend_cnt - 1'b1;
        if (pend_cnt == 1) begin rsp_valid <= 1'b1; outst <= 1'b0; end
      end
      if (cmd_valid && cmd_ready) begin
        if (outst) pf++;
        outst <= 1'b1; op_total <= op_total + 1; pend_cnt <= 2'd2;
        rsp_err <= 1'b0; rsp_data <= 8'h00;
        case (cmd_op)
          3'd0: begin cache <= mem[cmd_page]; rsp_err <= inj_err; end
          3'd1: rsp_data <= (cmd_col == CW'(PB)) ? cache : 8'h00;
          3'd2: wel <= 1'b1;
          3'd3: begin
            wel <= 1'b0;
            if (!wel) pf++;
            if (efail(int'(cmd_page) / PPB)) rsp_data <= 8'h04;
            else for (int i = 0; i < PPB; i++) mem[{cmd_page[PAW-1:2], 2'(i)}] <= 8'hFF;
          end
          3'd4: begin
            if (!wel || cmd_col != CW'(PB)) pf++;
            pend <= cmd_wdata;
          end
          3'd5: begin
            wel <= 1'b0;
            mem[cmd_page] <= mem[cmd_page] & pend;
            if (pfail(int'(cmd_page) / PPB)) rsp_data <= 8'h08;
          end
          default: pf++;
        endcase
      end
      proto_fail <= proto_fail + pf;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_req(input bit mark, input int page, output bit bad, output bit fault, output int ops);
    int ops0, n;
    @(negedge clk);
    req_valid = 1'b1; req_mark = mark; req_page = PAW'(page); ops0 = op_total;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 busy after accept", int'(busy), 1);
    chk("R1 ready low while busy", int'(req_ready), 0);
    n = 0;
    while (!done && n < 400) begin @(negedge clk); n++; end
    chk("R8 done seen", int'(done), 1);
    bad = res_bad; fault = res_fault; ops = op_total - ops0;
    @(negedge clk);
    chk("R8 single pulse", int'(done), 0);
    chk("R8 result held", int'(res_bad), int'(bad));
    chk("R1 idle after done", int'(req_ready), 1);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", nchk + 1, nfail + 1);
      $finish;
    end
  end

  initial begin
    bit b, f; int ops;
    rst_n = 1'b0; req_valid = 1'b0; req_mark = 1'b0; req_page = '0; inj_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 busy", int'(busy), 0);
    chk("R9 done", int'(done), 0);
    chk("R9 cmd_valid", int'(cmd_valid), 0);
    chk("R9 req_ready", int'(req_ready), 1);
    chk("R9 results", int'(res_bad) + int'(res_fault), 0);

    // R3/R4: check sweep over every page
    for (int p = 0; p < NPAGE; p++) begin
      bit two, eb;
      two = (p % PPB == 0) && pat(p) == 8'hFF;
      eb  = (pat(p) != 8'hFF) || (two && pat(p + 1) != 8'hFF);
      do_req(1'b0, p, b, f, ops);
      chk("R3 bad flag", int'(b), int'(eb));
      chk("R3 no fault", int'(f), 0);
      chk("R4 command count", ops, two ? 4 : 2);
    end

    // R5: transport error on page read
    inj_err = 1'b1;
    for (int p = 0; p < 8; p++) begin
      do_req(1'b0, p, b, f, ops);
      chk("R5 fault", int'(f), 1);
      chk("R5 not bad", int'(b), 0);
      chk("R5 stops early", ops, 1);
    end
    inj_err = 1'b0;

    // R6/R7: mark every block, on a page that walks through the block
    for (int k = 0; k < NBLK; k++) begin
      int q;
      q = k * PPB + (k % PPB);
      do_req(1'b1, q, b, f, ops);
      chk("R8 mark never bad", int'(b), 0);
      if (efail(k)) begin
        chk("R6 erase fail fault", int'(f), 1);
        chk("R6 no program", ops, 2);
        do_req(1'b0, k * PPB, b, f, ops);
        chk("R6 block untouched",
            int'(b), int'(pat(k * PPB) != 8'hFF || pat(k * PPB + 1) != 8'hFF));
      end else begin
        chk("R7 program fault", int'(f), int'(pfail(k)));
        chk("R7 command count", ops, 5);
        do_req(1'b0, k * PPB, b, f, ops);
        chk("R7 marked via first two pages", int'(b), int'((k % PPB) < 2));
        chk("R7 check no fault", int'(f), 0);
        if ((k % PPB) >= 2) begin
          do_req(1'b0, q, b, f, ops);
          chk("R4 unaligned marked page bad", int'(b), 1);
          chk("R4 unaligned single page", ops, 2);
        end
      end
    end

    chk("R2 command protocol", proto_fail, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule